// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block watches the stream of conversion results leaving an analog-to-digital converter. Two comparators each pick one channel and test its 12-bit straight-binary result against a programmed threshold. Each comparator raises a sticky flag only after its channel has met the condition a programmed number of times in a row. Software programs each comparator through a one-cycle write strobe and reads the flags. It clears a flag by pulsing the matching clear bit. The flag is also presented as an interrupt request gated by a per-comparator enable.

A window mode on comparator 0 turns the pair into a range detector. Comparator 0 then counts a result only when its own condition and comparator 1's condition both hold for that same result. An optional sticky wake-up flag per comparator records each flag-setting event. Software clears it separately.

Top module: `adc_thresh_mon`

## Requirements
- R1: The condition bit selects the test. A value of 0 means the result is less than the compare value, and 1 means the result is greater than or equal to it.
- R2: The compare value and the result are 12-bit unsigned numbers (0x000 to 0xFFF). A result equal to the compare value satisfies the greater-or-equal condition and fails the less-than condition.
- R3: The 4-bit match-count field holds the required run length minus one, giving runs of 1 to 16. With field value N, the flag sets on the clock edge that accepts the (N+1)-th consecutive qualifying result.
- R4: Only results on the comparator's own channel, with the comparator enabled, advance or reset its counter. Results on other channels leave the counter unchanged.
- R5: A result on the comparator's channel that fails the condition returns its counter to zero.
- R6: When a flag sets, the counter restarts from zero, so setting the flag again takes a new full run.
- R7: A flag stays set until its clear bit is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R8: With window mode on, comparator 0 counts a result on its channel only when both comparators' conditions hold for it. Comparator 1 keeps operating on its own channel unchanged.
- R9: Any configuration write resets that comparator's counter. An all-zero write disables the comparator, so no result can set its flag.
- R10: Each interrupt request output equals its flag ANDed with its interrupt enable input.
- R11: Each wake-up flag sets together with its compare flag and clears only through its own clear bit.
- R12: After reset, all flags, interrupt requests and wake-up flags are 0 and both comparators are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | A conversion result is present this cycle |
| res_ch | input | CH_W | Channel index of the result |
| res_data | input | RES_W | Unsigned conversion result |
| cfg_we | input | 2 | Per-comparator configuration write strobe |
| cfg_en | input | 1 | Write data: comparator enable |
| cfg_ch | input | CH_W | Write data: watched channel |
| cfg_val | input | RES_W | Write data: compare value |
| cfg_cond | input | 1 | Write data: 0 less-than, 1 greater-or-equal |
| cfg_mcnt | input | CNT_W | Write data: run length minus one |
| cfg_win | input | 1 | Write data: window mode (used by comparator 0 only) |
| flag_clr | input | 2 | Clear pulse per compare flag |
| wake_clr | input | 2 | Clear pulse per wake-up flag |
| irq_en | input | 2 | Interrupt enable per comparator |
| cmp_flag | output | 2 | Sticky compare flags (bit 0 is comparator 0) |
| irq | output | 2 | Gated interrupt requests |
| wake_flag | output | 2 | Sticky wake-up flags |

## Verification
The flag-setting edge of a comparator and a software clear of the same flag can land in one cycle. The bench provokes this by driving the final qualifying result of a run together with clear pulses for both flags. It expects the flag under a live run to stay at 1 and the other flag to drop to 0. A configuration rewrite arriving mid-run is judged the same way: the bench counts results after the rewrite and expects the flag on the new run's last result only.

// File: rtl/thr_mon_pkg.sv
package thr_mon_pkg;
   localparam int unsigned DEF_RES_W = 12;
   localparam int unsigned DEF_CH_W  = 5;
   localparam int unsigned DEF_CNT_W = 4;
   localparam int unsigned N_CMP     = 2;

   typedef enum logic {
      CMP_LT = 1'b0,
      CMP_GE = 1'b1
   } cmp_cond_e;
endpackage

// File: rtl/thr_cmp_lane.sv
module thr_cmp_lane
   import thr_mon_pkg::*;
#(
   parameter int unsigned RES_W     = DEF_RES_W,
   parameter int unsigned CH_W      = DEF_CH_W,
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter bit          ALLOW_WIN = 1'b0,
   parameter bit          HAS_WAKE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_en,
   input  logic [CH_W-1:0]  cfg_ch,
   input  logic [RES_W-1:0] cfg_val,
   input  logic             cfg_cond,
   input  logic [CNT_W-1:0] cfg_mcnt,
   input  logic             cfg_win,
   input  logic             res_vld,
   input  logic [CH_W-1:0]  res_ch,
   input  logic [RES_W-1:0] res_data,
   input  logic             peer_hit,
   output logic             own_hit,
   input  logic             flag_clr,
   input  logic             wake_clr,
   output logic             flag,
   output logic             wake
);
   localparam logic WIN_OK = ALLOW_WIN;

   logic             en_q, win_q, flag_q;
   cmp_cond_e        cond_q;
   logic [CH_W-1:0]  ch_q;
   logic [RES_W-1:0] val_q;
   logic [CNT_W-1:0] lim_q, cnt_q;
   logic             sel, match, fire, use_win;

   // condition evaluated on every result, independent of channel
   assign own_hit = (cond_q == CMP_GE) ? (res_data >= val_q) : (res_data < val_q);
   assign use_win = win_q & WIN_OK;
   assign sel     = res_vld && en_q && (res_ch == ch_q);
   assign match   = own_hit && (!use_win || peer_hit);
   assign fire    = sel && match && (cnt_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         win_q  <= 1'b0;
         cond_q <= CMP_LT;
         ch_q   <= '0;
         val_q  <= '0;
         lim_q  <= '0;
      end else if (cfg_we) begin
         en_q   <= cfg_en;
         win_q  <= cfg_win;
         cond_q <= cmp_cond_e'(cfg_cond);
         ch_q   <= cfg_ch;
         val_q  <= cfg_val;
         lim_q  <= cfg_mcnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (cfg_we)           cnt_q <= '0;
      else if (sel) begin
         if (!match || fire)     cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (fire)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end
   assign flag = flag_q;

   generate
      if (HAS_WAKE) begin : g_wake
         logic wake_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        wake_q <= 1'b0;
            else if (fire)     wake_q <= 1'b1;
            else if (wake_clr) wake_q <= 1'b0;
         end
         assign wake = wake_q;

         // R11: wake flag only appears alongside a set compare flag
         a_r11_wake_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wake_q) |-> flag_q);
      end else begin : g_nowake
         assign wake = 1'b0;
      end
   endgenerate

   // R4: a flag rises only after a result on the watched, enabled channel
   a_r4_rise_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(res_vld && res_ch == ch_q && en_q));
   // R3: counter never passes the programmed limit
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q);
   // R7: a clear with no result on the channel drops the flag
   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !sel) |=> !flag_q);
   // R9: configuration write restarts the run; zero write disables
   a_r9_cfg_restart: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cnt_q == '0) && (en_q == $past(cfg_en)));
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
   import thr_mon_pkg::*;
#(
   parameter int unsigned RES_W    = DEF_RES_W,
   parameter int unsigned CH_W     = DEF_CH_W,
   parameter int unsigned CNT_W    = DEF_CNT_W,
   parameter bit          HAS_WAKE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_vld,
   input  logic [CH_W-1:0]  res_ch,
   input  logic [RES_W-1:0] res_data,
   input  logic [1:0]       cfg_we,
   input  logic             cfg_en,
   input  logic [CH_W-1:0]  cfg_ch,
   input  logic [RES_W-1:0] cfg_val,
   input  logic             cfg_cond,
   input  logic [CNT_W-1:0] cfg_mcnt,
   input  logic             cfg_win,
   input  logic [1:0]       flag_clr,
   input  logic [1:0]       wake_clr,
   input  logic [1:0]       irq_en,
   output logic [1:0]       cmp_flag,
   output logic [1:0]       irq,
   output logic [1:0]       wake_flag
);
   generate
      if (RES_W < 2 || CH_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("adc_thresh_mon: widths out of range");
      end
      if (N_CMP != 2) begin : g_bad_count
         $error("adc_thresh_mon: exactly two comparators are supported");
      end
   endgenerate

   logic [N_CMP-1:0] hit;

   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_lane
         thr_cmp_lane #(
            .RES_W     (RES_W),
            .CH_W      (CH_W),
            .CNT_W     (CNT_W),
            .ALLOW_WIN (i == 0),
            .HAS_WAKE  (HAS_WAKE)
         ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[i]),
            .cfg_en   (cfg_en),
            .cfg_ch   (cfg_ch),
            .cfg_val  (cfg_val),
            .cfg_cond (cfg_cond),
            .cfg_mcnt (cfg_mcnt),
            .cfg_win  (cfg_win),
            .res_vld  (res_vld),
            .res_ch   (res_ch),
            .res_data (res_data),
            .peer_hit (hit[(i + 1) % N_CMP]),
            .own_hit  (hit[i]),
            .flag_clr (flag_clr[i]),
            .wake_clr (wake_clr[i]),
            .flag     (cmp_flag[i]),
            .wake     (wake_flag[i])
         );
      end
   endgenerate

   assign irq = cmp_flag & irq_en;
endmodule

// File: tb/adc_thresh_mon_tb.sv
module adc_thresh_mon_tb_top;
   localparam int CLK_PER = 10;
   localparam int RW = 12, CW = 5, NW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic res_vld = 1'b0;
   logic [CW-1:0] res_ch = '0;
   logic [RW-1:0] res_data = '0;
   logic [1:0] cfg_we = '0;
   logic cfg_en = 1'b0, cfg_cond = 1'b0, cfg_win = 1'b0;
   logic [CW-1:0] cfg_ch = '0;
   logic [RW-1:0] cfg_val = '0;
   logic [NW-1:0] cfg_mcnt = '0;
   logic [1:0] flag_clr = '0, wake_clr = '0, irq_en = '0;
   logic [1:0] cmp_flag, irq, wake_flag;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   adc_thresh_mon dut_i (
      .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch), .res_data(res_data),
      .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_ch(cfg_ch), .cfg_val(cfg_val),
      .cfg_cond(cfg_cond), .cfg_mcnt(cfg_mcnt), .cfg_win(cfg_win),
      .flag_clr(flag_clr), .wake_clr(wake_clr), .irq_en(irq_en),
      .cmp_flag(cmp_flag), .irq(irq), .wake_flag(wake_flag));

   // {channel, result, expected cmp_flag}
   localparam logic [CW+RW+1:0] VEC [0:8] = '{
      {5'd3, 12'h800, 2'b00},  // R2 equality counts for GE
      {5'd3, 12'hFFF, 2'b00},
      {5'd7, 12'h000, 2'b00},  // R4 other channel, count kept
      {5'd3, 12'h7FF, 2'b00},  // R5 failure resets
      {5'd3, 12'h900, 2'b00},
      {5'd3, 12'h900, 2'b00},
      {5'd3, 12'h900, 2'b01},  // R3 third in a row sets comparator 0
      {5'd5, 12'h0FF, 2'b11},  // R1 less-than on comparator 1
      {5'd5, 12'h100, 2'b11}
   };

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input int idx, input logic en, input logic [CW-1:0] ch,
                         input logic [RW-1:0] val, input logic cond,
                         input logic [NW-1:0] mc, input logic win);
      @(negedge clk);
      cfg_we = '0; cfg_we[idx] = 1'b1;
      cfg_en = en; cfg_ch = ch; cfg_val = val; cfg_cond = cond; cfg_mcnt = mc; cfg_win = win;
      @(negedge clk);
      cfg_we = '0;
   endtask

   task automatic send(input logic [CW-1:0] ch, input logic [RW-1:0] d, input logic [1:0] clr);
      @(negedge clk);
      res_vld = 1'b1; res_ch = ch; res_data = d; flag_clr = clr;
      @(negedge clk);
      res_vld = 1'b0; flag_clr = '0;
   endtask

   task automatic clear_flags();
      @(negedge clk);
      flag_clr = 2'b11;
      @(negedge clk);
      flag_clr = '0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 flags", cmp_flag, 2'b00);
      chk("R12 irq", irq, 2'b00);
      chk("R12 wake", wake_flag, 2'b00);

      wr_cfg(0, 1'b1, 5'd3, 12'h800, 1'b1, 4'd2, 1'b0);
      wr_cfg(1, 1'b1, 5'd5, 12'h100, 1'b0, 4'd0, 1'b0);
      irq_en = 2'b11;
      for (int k = 0; k < 9; k++) begin
         send(VEC[k][CW+RW+1:RW+2], VEC[k][RW+1:2], 2'b00);
         chk($sformatf("R1-table vector %0d (R3 R4 R5)", k), cmp_flag, VEC[k][1:0]);
      end

      irq_en = 2'b01;
      @(negedge clk);
      chk("R10 irq gated", irq, 2'b01);
      irq_en = 2'b11;
      chk("R11 wake set", wake_flag, 2'b11);
      @(negedge clk); wake_clr = 2'b11;
      @(negedge clk); wake_clr = '0;
      chk("R11 wake cleared", wake_flag, 2'b00);
      chk("R11 flags kept", cmp_flag, 2'b11);
      clear_flags();
      chk("R7 clear", cmp_flag, 2'b00);

      send(5'd5, 12'h100, 2'b00);
      chk("R2 equal fails less-than", cmp_flag, 2'b00);

      // R6: counter restarted when flag set at vector 6
      send(5'd3, 12'h900, 2'b00);
      chk("R6 new run first", cmp_flag, 2'b00);
      send(5'd3, 12'h900, 2'b00);
      send(5'd3, 12'h900, 2'b00);
      chk("R6 new run complete", cmp_flag, 2'b01);

      // R7: set on comparator 1 and clear of both in one cycle
      send(5'd5, 12'h0FF, 2'b11);
      chk("R7 set wins over clear", cmp_flag, 2'b10);

      // R9: rewrite mid-run restarts the count
      clear_flags();
      send(5'd3, 12'h900, 2'b00);
      send(5'd3, 12'h900, 2'b00);
      wr_cfg(0, 1'b1, 5'd3, 12'h800, 1'b1, 4'd2, 1'b0);
      send(5'd3, 12'h900, 2'b00);
      send(5'd3, 12'h900, 2'b00);
      chk("R9 rewrite restarts run", cmp_flag, 2'b00);
      send(5'd3, 12'h900, 2'b00);
      chk("R9 run after rewrite", cmp_flag, 2'b01);
      wr_cfg(0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
      clear_flags();
      for (int k = 0; k < 4; k++) send(5'd3, 12'h900, 2'b00);
      chk("R9 zero write disables", cmp_flag, 2'b00);

      // R3: longest run of 16
      wr_cfg(0, 1'b1, 5'd0, 12'h001, 1'b0, 4'd15, 1'b0);
      for (int k = 0; k < 15; k++) send(5'd0, 12'h000, 2'b00);
      chk("R3 fifteen not enough", cmp_flag, 2'b00);
      send(5'd0, 12'h000, 2'b00);
      chk("R3 sixteenth sets", cmp_flag, 2'b01);

      // R8: window between 0x400 and 0xC00 on channel 2
      clear_flags();
      wr_cfg(0, 1'b1, 5'd2, 12'h400, 1'b1, 4'd0, 1'b1);
      wr_cfg(1, 1'b1, 5'd9, 12'hC00, 1'b0, 4'd0, 1'b0);
      send(5'd2, 12'hD00, 2'b00);
      chk("R8 above window", cmp_flag, 2'b00);
      send(5'd2, 12'h500, 2'b00);
      chk("R8 inside window", cmp_flag, 2'b01);
      send(5'd9, 12'h100, 2'b00);
      chk("R8 comparator 1 independent", cmp_flag, 2'b11);

      done = 1'b1;
      finish_run();
   end
endmodule